// File: doc/BRIEF.md
# Latched Interrupt Collector with Single-Read Release

This block gathers one-cycle event pulses from five detectors: new acceleration data, motion wake-up, orientation change, tap and buffer watermark. It holds them in two source registers, one for functions and one for tap direction, and raises a combined status bit. It also drives one physical interrupt pin. The pin has an enable, a selectable polarity and three response modes: latched, fixed-width pulse, and a motion-only mode in which the pin tracks the live motion state.

Software clears everything by reading one release register. That single read empties both source registers, drops the status bit and returns a latched pin to its inactive level. A read of the acceleration outputs clears only the data-ready and motion flags. An event that arrives in the same cycle as either read is kept.

No data stream crosses this block. Every input is a plain strobe, level or configuration bit, and every output is a plain register value or pin level. There is therefore no valid/ready handshake and no back-pressure.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset both source registers read 0x00, `irq_status` is 0, and `irq_pin` sits at its inactive level: 0 when `pin_pol`=1, 1 when `pin_pol`=0, and also 1 whenever `pin_en`=0 with `pin_pol`=0.
- R2: `src_func` bit layout is: [7:6]=0, [5]=watermark, [4]=data ready, [3:2]=tap kind, [1]=motion, [0]=tilt change.
- R3: An event pulse whose function enable (`en_drdy`, `en_motion`, `en_tilt`, `en_tap`, `en_wmark`) is 0 changes no source bit and does not disturb the pin.
- R4: A tilt event sets bit 0 only when the new one-hot orientation `tilt_pos` overlaps `tilt_mask`.
- R5: A release read (`rd_release` for one cycle) with no accepted event clears both source registers, `irq_status` and a latched or pulsing pin on the next clock edge.
- R6: An acceleration read (`rd_accel`) clears bits 4 and 1 only; the other bits and the latched pin keep their values.
- R7: An accepted event in the same cycle as a release read or an acceleration read is latched and not lost.
- R8: `irq_status` is 1 exactly when some bit of `src_func` is 1.
- R9: `irq_pin` equals `pin_pol` while `pin_en`=1 and the pin is active; otherwise it equals the inverse of `pin_pol`.
- R10: With `pin_pulse`=0 the pin turns active on the edge that accepts an event and stays active until a release read, whatever else happens.
- R11: With `pin_pulse`=1 the pin is active for exactly `PULSE_CYC` cycles after the edge that accepts an event. A later event restarts the full count.
- R12: With `pin_unlatched`=1 and motion as the only enabled function, the pin follows `motion_live` combinationally. With any other function also enabled, `pin_unlatched` has no effect.
- R13: A tap event with `tap_kind` 01 (single) or 10 (double) writes the kind into bits [3:2]. The same event ORs `tap_dir` into `src_tap_dir[5:0]`, whose bits [7:6] are 0. Kind 11 or 00 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ev_drdy | input | 1 | new acceleration data pulse |
| ev_motion | input | 1 | motion wake-up pulse |
| motion_live | input | 1 | live motion level for unlatched mode |
| ev_tilt | input | 1 | orientation change pulse |
| tilt_pos | input | 6 | new orientation, one-hot |
| ev_tap | input | 1 | tap detected pulse |
| tap_kind | input | 2 | 01 single, 10 double |
| tap_dir | input | 6 | tap direction bits |
| ev_wmark | input | 1 | buffer watermark pulse |
| en_drdy | input | 1 | data-ready reporting enable |
| en_motion | input | 1 | motion function enable |
| en_tilt | input | 1 | tilt function enable |
| en_tap | input | 1 | tap function enable |
| en_wmark | input | 1 | watermark enable |
| tilt_mask | input | 6 | orientations that may interrupt |
| pin_en | input | 1 | pin output enable |
| pin_pol | input | 1 | 1 active high, 0 active low |
| pin_pulse | input | 1 | 0 latched, 1 pulse response |
| pin_unlatched | input | 1 | motion-only follow mode |
| rd_release | input | 1 | release register read strobe |
| rd_accel | input | 1 | acceleration output read strobe |
| src_func | output | 8 | function source register |
| src_tap_dir | output | 8 | tap direction source register |
| irq_status | output | 1 | OR of latched sources |
| irq_pin | output | 1 | physical interrupt pin |

## Verification
The assertions assume that the event inputs are single-cycle strobes sampled on the rising edge. They also assume that `tilt_pos` carries at most one set bit and that configuration bits change only between events. The bench drives every strobe for exactly one cycle from the falling edge and keeps `tilt_pos` one-hot. It changes configuration only while no strobe is pending. Because of this, each expected register value can be worked out from the sweep index alone.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DIRS      = 6;
  localparam int REG_W     = 8;
  localparam int B_TILT    = 0;
  localparam int B_MOTION  = 1;
  localparam int B_TAP_LO  = 2;
  localparam int B_TAP_HI  = 3;
  localparam int B_DRDY    = 4;
  localparam int B_WMARK   = 5;
  localparam int USED_BITS = 6;

  typedef struct packed {
    logic wmark;
    logic tap;
    logic tilt;
    logic motion;
    logic drdy;
  } fn_en_t;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_drdy,
  input  logic             ev_motion,
  input  logic             ev_tilt,
  input  logic [DIRS-1:0]  tilt_pos,
  input  logic [DIRS-1:0]  tilt_mask,
  input  logic             ev_tap,
  input  logic [1:0]       tap_kind,
  input  logic [DIRS-1:0]  tap_dir,
  input  logic             ev_wmark,
  input  fn_en_t           en,
  input  logic             rd_release,
  input  logic             rd_accel,
  output logic [REG_W-1:0] func_q,
  output logic [REG_W-1:0] dir_q,
  output logic             fresh
);
  logic acc_drdy, acc_mot, acc_tilt, acc_tap, acc_wm;
  logic [REG_W-1:0] keep_f, keep_d, func_n, dir_n;

  assign acc_drdy = ev_drdy & en.drdy;
  assign acc_mot  = ev_motion & en.motion;
  assign acc_tilt = ev_tilt & en.tilt & (|(tilt_pos & tilt_mask));
  assign acc_tap  = ev_tap & en.tap & (tap_kind[0] ^ tap_kind[1]);
  assign acc_wm   = ev_wmark & en.wmark;
  assign fresh    = acc_drdy | acc_mot | acc_tilt | acc_tap | acc_wm;

  always_comb begin
    keep_f = rd_release ? '0 : func_q;
    if (rd_accel) begin
      keep_f[B_DRDY]   = 1'b0;
      keep_f[B_MOTION] = 1'b0;
    end
    keep_d = rd_release ? '0 : dir_q;
    func_n = '0;
    func_n[B_WMARK]  = keep_f[B_WMARK] | acc_wm;
    func_n[B_DRDY]   = keep_f[B_DRDY] | acc_drdy;
    func_n[B_MOTION] = keep_f[B_MOTION] | acc_mot;
    func_n[B_TILT]   = keep_f[B_TILT] | acc_tilt;
    func_n[B_TAP_HI:B_TAP_LO] = acc_tap ? tap_kind : keep_f[B_TAP_HI:B_TAP_LO];
    dir_n = '0;
    dir_n[DIRS-1:0] = keep_d[DIRS-1:0] | (acc_tap ? tap_dir : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      dir_q  <= '0;
    end else begin
      func_q <= func_n;
      dir_q  <= dir_n;
    end
  end

  // R5
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release && !fresh |=> func_q == '0 && dir_q == '0);
  // R6
  accel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accel && !acc_drdy && !acc_mot |=> !func_q[B_DRDY] && !func_q[B_MOTION]);
  // R7
  drdy_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_drdy |=> func_q[B_DRDY]);
  // R3
  drdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en.drdy && !rd_release && !rd_accel |=> $stable(func_q[B_DRDY]));
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_q[REG_W-1:USED_BITS] == '0 && dir_q[REG_W-1:DIRS] == '0);
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
  parameter int PULSE_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fresh,
  input  logic rd_release,
  input  logic pin_en,
  input  logic pin_pol,
  input  logic pin_pulse,
  input  logic pin_unlatched,
  input  logic motion_only,
  input  logic motion_live,
  output logic pin
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic          latch_q;
  logic [CW-1:0] cnt_q;
  logic          act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (fresh)           latch_q <= 1'b1;
      else if (rd_release) latch_q <= 1'b0;
      if (fresh)              cnt_q <= LOAD;
      else if (rd_release)    cnt_q <= '0;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    if (pin_unlatched && motion_only) act = motion_live;
    else if (pin_pulse)               act = (cnt_q != '0);
    else                              act = latch_q;
  end

  assign pin = (pin_en && act) ? pin_pol : ~pin_pol;

  // R11
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
  // R11
  pulse_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |=> cnt_q == LOAD && latch_q);
  // R5
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release && !fresh |=> !latch_q && cnt_q == '0);
  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q && !rd_release |=> latch_q);
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_pkg::*;
#(
  parameter int PULSE_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_drdy,
  input  logic       ev_motion,
  input  logic       motion_live,
  input  logic       ev_tilt,
  input  logic [5:0] tilt_pos,
  input  logic       ev_tap,
  input  logic [1:0] tap_kind,
  input  logic [5:0] tap_dir,
  input  logic       ev_wmark,
  input  logic       en_drdy,
  input  logic       en_motion,
  input  logic       en_tilt,
  input  logic       en_tap,
  input  logic       en_wmark,
  input  logic [5:0] tilt_mask,
  input  logic       pin_en,
  input  logic       pin_pol,
  input  logic       pin_pulse,
  input  logic       pin_unlatched,
  input  logic       rd_release,
  input  logic       rd_accel,
  output logic [7:0] src_func,
  output logic [7:0] src_tap_dir,
  output logic       irq_status,
  output logic       irq_pin
);
  fn_en_t en;
  logic   fresh;
  logic   motion_only;

  assign en = '{wmark: en_wmark, tap: en_tap, tilt: en_tilt,
                motion: en_motion, drdy: en_drdy};
  assign motion_only = en_motion & ~en_drdy & ~en_tilt & ~en_tap & ~en_wmark;

  irq_src_latch u_src (
    .clk(clk), .rst_n(rst_n),
    .ev_drdy(ev_drdy), .ev_motion(ev_motion),
    .ev_tilt(ev_tilt), .tilt_pos(tilt_pos), .tilt_mask(tilt_mask),
    .ev_tap(ev_tap), .tap_kind(tap_kind), .tap_dir(tap_dir),
    .ev_wmark(ev_wmark), .en(en),
    .rd_release(rd_release), .rd_accel(rd_accel),
    .func_q(src_func), .dir_q(src_tap_dir), .fresh(fresh)
  );

  irq_pin_drive #(.PULSE_CYC(PULSE_CYC)) u_pin (
    .clk(clk), .rst_n(rst_n), .fresh(fresh), .rd_release(rd_release),
    .pin_en(pin_en), .pin_pol(pin_pol), .pin_pulse(pin_pulse),
    .pin_unlatched(pin_unlatched), .motion_only(motion_only),
    .motion_live(motion_live), .pin(irq_pin)
  );

  assign irq_status = |src_func[USED_BITS-1:0];

  // R9
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> irq_pin == ~pin_pol);
  // R12
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_en && pin_unlatched && motion_only |-> irq_pin == (motion_live ? pin_pol : ~pin_pol));
endmodule

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  localparam int PW = 5;
  logic clk = 0, rst_n = 0;
  logic ev_drdy = 0, ev_motion = 0, motion_live = 0, ev_tilt = 0, ev_tap = 0, ev_wmark = 0;
  logic [5:0] tilt_pos = 0, tap_dir = 0, tilt_mask = 6'h3F;
  logic [1:0] tap_kind = 0;
  logic en_drdy = 1, en_motion = 1, en_tilt = 1, en_tap = 1, en_wmark = 1;
  logic pin_en = 1, pin_pol = 1, pin_pulse = 0, pin_unlatched = 0;
  logic rd_release = 0, rd_accel = 0;
  logic [7:0] src_func, src_tap_dir;
  logic irq_status, irq_pin;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_latch_ctrl #(.PULSE_CYC(PW)) i_irq_latch_ctrl (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ev_drdy = 0; ev_motion = 0; ev_tilt = 0; ev_tap = 0; ev_wmark = 0;
    rd_release = 0; rd_accel = 0;
  endtask

  task automatic release_all();
    rd_release = 1; step();
  endtask

  task automatic fire_all();
    ev_drdy = 1; ev_motion = 1; ev_wmark = 1;
    ev_tilt = 1; tilt_pos = 6'h01;
    ev_tap = 1; tap_kind = 2'b01; tap_dir = 6'h01;
    step();
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 func", src_func, 8'h00);
    chk("R1 dir", src_tap_dir, 8'h00);
    chk("R1 status", {7'd0, irq_status}, 8'h00);
    chk("R1 pin", {7'd0, irq_pin}, 8'h00);
    pin_pol = 0; #1;
    chk("R1 pin low-pol", {7'd0, irq_pin}, 8'h01);
    pin_pol = 1;
    @(negedge clk); rst_n = 1; @(negedge clk);

    // R2 single sources at their bit positions
    ev_drdy = 1; step(); chk("R2 drdy", src_func, 8'h10); release_all();
    ev_motion = 1; step(); chk("R2 motion", src_func, 8'h02); release_all();
    ev_wmark = 1; step(); chk("R2 wmark", src_func, 8'h20); release_all();
    ev_tilt = 1; tilt_pos = 6'h08; step(); chk("R2 tilt", src_func, 8'h01); release_all();
    // R13 tap kinds and direction
    ev_tap = 1; tap_kind = 2'b01; tap_dir = 6'h04; step();
    chk("R13 single", src_func, 8'h04); chk("R13 dir", src_tap_dir, 8'h04);
    ev_tap = 1; tap_kind = 2'b10; tap_dir = 6'h20; step();
    chk("R13 double", src_func, 8'h08); chk("R13 dir or", src_tap_dir, 8'h24);
    release_all();
    chk("R5 func", src_func, 8'h00); chk("R5 dir", src_tap_dir, 8'h00);
    chk("R5 pin", {7'd0, irq_pin}, 8'h00);
    ev_tap = 1; tap_kind = 2'b11; tap_dir = 6'h01; step();
    chk("R13 kind11", src_func, 8'h00); chk("R13 kind11 pin", {7'd0, irq_pin}, 8'h00);

    // R3 / R8 enable sweep over all 32 enable patterns
    for (int e = 0; e < 32; e++) begin
      logic [7:0] ef, ed;
      {en_wmark, en_tap, en_tilt, en_motion, en_drdy} = 5'(e);
      ef = (e[0] ? 8'h10 : 0) | (e[1] ? 8'h02 : 0) | (e[2] ? 8'h01 : 0)
         | (e[3] ? 8'h04 : 0) | (e[4] ? 8'h20 : 0);
      ed = e[3] ? 8'h01 : 8'h00;
      fire_all();
      chk("R3 func", src_func, ef);
      chk("R13 dir", src_tap_dir, ed);
      chk("R8 status", {7'd0, irq_status}, {7'd0, ef != 0});
      chk("R3 pin", {7'd0, irq_pin}, {7'd0, ef != 0});
      release_all();
    end
    {en_wmark, en_tap, en_tilt, en_motion, en_drdy} = 5'h1F;

    // R4 tilt mask sweep
    for (int o = 0; o < 6; o++)
      for (int m = 0; m < 64; m++) begin
        tilt_mask = 6'(m); ev_tilt = 1; tilt_pos = 6'(1 << o); step();
        chk("R4 tilt", src_func, {7'd0, m[o]});
        release_all();
      end
    tilt_mask = 6'h3F;

    // R6 acceleration read
    fire_all(); rd_accel = 1; step();
    chk("R6 partial", src_func, 8'h25);
    chk("R6 status", {7'd0, irq_status}, 8'h01);
    chk("R10 pin after accel", {7'd0, irq_pin}, 8'h01);
    // R7 event alongside reads
    ev_drdy = 1; rd_accel = 1; step();
    chk("R7 accel+drdy", src_func, 8'h35);
    ev_drdy = 1; rd_release = 1; step();
    chk("R7 release+drdy", src_func, 8'h10);
    chk("R7 pin", {7'd0, irq_pin}, 8'h01);
    release_all();

    // R10 latched hold
    ev_wmark = 1; step();
    repeat (20) @(negedge clk);
    chk("R10 hold", {7'd0, irq_pin}, 8'h01);
    // R9 polarity and enable
    pin_pol = 0; #1; chk("R9 low active", {7'd0, irq_pin}, 8'h00);
    pin_en = 0; #1; chk("R9 off lowpol", {7'd0, irq_pin}, 8'h01);
    pin_pol = 1; #1; chk("R9 off highpol", {7'd0, irq_pin}, 8'h00);
    pin_en = 1; #1; chk("R9 on", {7'd0, irq_pin}, 8'h01);
    release_all();
    chk("R10 released", {7'd0, irq_pin}, 8'h00);

    // R11 pulse width and restart
    pin_pulse = 1;
    begin
      int hi = 0;
      ev_drdy = 1; step();
      for (int i = 0; i < 12; i++) begin hi += irq_pin; @(negedge clk); end
      chk("R11 width", 8'(hi), 8'(PW));
      hi = 0;
      ev_drdy = 1; step(); hi += irq_pin; @(negedge clk); hi += irq_pin; @(negedge clk);
      ev_motion = 1; step();
      for (int i = 0; i < 12; i++) begin hi += irq_pin; @(negedge clk); end
      chk("R11 restart", 8'(hi), 8'(PW + 2));
      ev_drdy = 1; step(); rd_release = 1; step();
      chk("R11 release cut", {7'd0, irq_pin}, 8'h00);
    end
    pin_pulse = 0;
    release_all();

    // R12 motion-only follow mode
    {en_wmark, en_tap, en_tilt, en_drdy} = 4'h0; pin_unlatched = 1;
    motion_live = 1; #1; chk("R12 follow hi", {7'd0, irq_pin}, 8'h01);
    ev_motion = 1; step(); motion_live = 0; #1;
    chk("R12 follow lo", {7'd0, irq_pin}, 8'h00);
    chk("R12 wufs latched", src_func, 8'h02);
    en_drdy = 1; #1;
    chk("R12 not sole", {7'd0, irq_pin}, 8'h01);
    release_all();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule